// File: doc/BRIEF.md
# MSI Termination and Pending-Status Unit

This block receives message-signalled interrupts that arrive as memory writes from the device side, stores each one as a pending bit, and raises one interrupt line per frame. The block holds 16 frames. Each frame has 8 termination registers, and each termination register tracks 16 vectors, for 2048 vectors in all. A device posts a vector by writing to a termination register. The low bits of the write data name the vector.

On the CPU side, a read of a termination register returns its pending bitmap one cycle later. The same read also acknowledges and clears every vector it returned. Each frame also has a summary register. The summary register shows which of the frame's termination registers hold anything pending, so interrupt service can go straight to the busy registers. Reading a summary register clears nothing.

The register map is sparse. Each register sits at the start of its own 64 kB region. Termination register (frame n, index x) is at byte offset n*0x80000 + x*0x10000. The summary register of frame n is at 0x800000 + n*0x10000. Every other offset is unmapped.

Top module: `msi_term_unit`

## Requirements
- R1: After a synchronous active-low reset, no vector is pending, every interrupt output is low, and every read returns zero.
- R2: A write to termination register (n, x), at offset n*0x80000 + x*0x10000, sets the vector named by write-data bits 3:0 in that register. All other write-data bits are ignored.
- R3: A read of a termination register returns its pending bitmap in rd_data bits 15:0 in the cycle after rd_en. rd_data bits 31:16 read as zero.
- R4: A termination-register read clears exactly the vectors it returned. An immediate second read of the same register returns zero.
- R5: Writing a vector that is already pending leaves it pending, as a single bit, with no other vector changed.
- R6: The summary register of frame n, at 0x800000 + n*0x10000, returns in bits 7:0 the OR of each of the frame's termination registers (bit x set when register x has any vector pending). Bits 31:8 read as zero. Reading it changes no pending state.
- R7: irq[n] is high exactly when some vector in frame n is pending.
- R8: Writes to summary registers are ignored. So are writes to unmapped offsets: any offset that is not a multiple of 0x10000, and anything at or above 0x900000. Reads of unmapped offsets return zero and clear nothing.
- R9: When a device write and a CPU read of the same termination register occur in the same cycle, the written vector remains pending afterwards unless it was set in the bitmap that read returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Device-side write strobe |
| wr_addr | input | 24 | Byte offset of the device write |
| wr_data | input | 32 | Write data; bits 3:0 name the vector |
| rd_en | input | 1 | CPU-side read strobe |
| rd_addr | input | 24 | Byte offset of the CPU read |
| rd_data | output | 32 | Read result, valid in the cycle after rd_en |
| irq | output | 16 | One interrupt output per frame |

## Verification
The bench builds the block with its default parameters: 16 frames of 8 registers, 16 vectors each, and a 64 kB stride. With those values the last frame's last register at 0x7F0000, the last summary register at 0x8F0000 and the first unmapped slot at 0x900000 are all at their real offsets. That lets the bench exercise both map boundaries and a misaligned offset. A scoreboard predicts every read from the requirements, including cycles where a write and a read of the same register coincide.

// File: rtl/msi_term_pkg.sv
// msi_term_pkg: types shared by the MSI termination unit.
// Assumes nothing beyond the address-hit classification used by the decoder and top.
package msi_term_pkg;

    // Class of register an access lands on
    typedef enum logic [1:0] {
        HIT_NONE = 2'd0,
        HIT_TERM = 2'd1,
        HIT_SUM  = 2'd2
    } hit_e;

endpackage

// File: rtl/msi_addr_decode.sv
// msi_addr_decode: maps a byte offset onto a termination register or a
// summary register, or onto nothing.
// Assumes REGS_PER_FRAME is a power of two (at least 2). Registers sit at the
// start of 2**STRIDE_LOG2-byte regions. Termination slots come first, in
// frame-major order, and the summary slots follow them.
module msi_addr_decode
    import msi_term_pkg::*;
#(
    parameter int NUM_FRAMES     = 16,
    parameter int REGS_PER_FRAME = 8,
    parameter int STRIDE_LOG2    = 16,
    parameter int ADDR_W         = 24,
    parameter int FRAME_W        = 4,
    parameter int IDX_W          = 3
) (
    input  logic [ADDR_W-1:0]  addr,
    output hit_e               hit,
    output logic [FRAME_W-1:0] frame,
    output logic [IDX_W-1:0]   idx
);
    localparam int SLOT_W     = ADDR_W - STRIDE_LOG2;
    localparam int TERM_SLOTS = NUM_FRAMES * REGS_PER_FRAME;
    localparam int ALL_SLOTS  = TERM_SLOTS + NUM_FRAMES;

    logic [SLOT_W-1:0] slot;
    logic              aligned;

    // Classify the offset and split the slot number into frame and index
    always_comb begin
        slot    = addr[ADDR_W-1:STRIDE_LOG2];
        aligned = (addr[STRIDE_LOG2-1:0] == '0);
        hit     = HIT_NONE;
        frame   = '0;
        idx     = '0;
        if (aligned) begin
            if (int'(slot) < TERM_SLOTS) begin
                hit   = HIT_TERM;
                idx   = slot[IDX_W-1:0];
                frame = FRAME_W'(slot >> IDX_W);
            end else if (int'(slot) < ALL_SLOTS) begin
                hit   = HIT_SUM;
                frame = FRAME_W'(int'(slot) - TERM_SLOTS);
            end
        end
    end

endmodule

// File: rtl/msi_pend_bank.sv
// msi_pend_bank: pending storage for one frame. Holds REGS_PER_FRAME
// registers of VECS_PER_REG vectors each, and produces the frame summary and
// its interrupt.
// Assumes at most one set and one read-clear per cycle. The clear removes
// exactly the bits visible on sel_bits in that cycle, applied after the set.
module msi_pend_bank #(
    parameter int REGS_PER_FRAME = 8,
    parameter int VECS_PER_REG   = 16,
    parameter int IDX_W          = 3,
    parameter int VEC_W          = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      set_en,
    input  logic [IDX_W-1:0]          set_idx,
    input  logic [VEC_W-1:0]          set_vec,
    input  logic                      clr_en,
    input  logic [IDX_W-1:0]          clr_idx,
    output logic [VECS_PER_REG-1:0]   sel_bits,
    output logic [REGS_PER_FRAME-1:0] summary,
    output logic                      irq
);
    logic [VECS_PER_REG-1:0] pend [REGS_PER_FRAME];
    logic [VECS_PER_REG-1:0] nxt  [REGS_PER_FRAME];

    // Expose the register addressed by the read side
    assign sel_bits = pend[clr_idx];

    // Next state per register: merge the set, then drop the reported bits
    always_comb begin
        for (int r = 0; r < REGS_PER_FRAME; r++) begin
            logic [VECS_PER_REG-1:0] smask;
            logic [VECS_PER_REG-1:0] cmask;
            smask = '0;
            cmask = '0;
            if (set_en && (set_idx == IDX_W'(r)))
                smask[set_vec] = 1'b1;
            if (clr_en && (clr_idx == IDX_W'(r)))
                cmask = pend[r];
            nxt[r] = (pend[r] | smask) & ~cmask;
        end
    end

    // Pending register update with synchronous reset
    always_ff @(posedge clk) begin
        for (int r = 0; r < REGS_PER_FRAME; r++) begin
            if (!rst_n) pend[r] <= '0;
            else        pend[r] <= nxt[r];
        end
    end

    // Summary bits: one per register, set when it holds any vector
    generate
        for (genvar g = 0; g < REGS_PER_FRAME; g++) begin : g_sum
            assign summary[g] = |pend[g];
        end
    endgenerate

    // Frame interrupt from the summary
    assign irq = |summary;

    AST_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !(clr_en && clr_idx == set_idx))
        |=> pend[$past(set_idx)][$past(set_vec)]);                       // R2
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((pend[$past(clr_idx)] & $past(sel_bits)) == '0));   // R4
    AST_IRQ_RISE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(set_en));                                   // R7
    AST_IRQ_FALL_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(clr_en));                                   // R7

endmodule

// File: rtl/msi_term_unit.sv
// msi_term_unit: MSI termination unit. Device writes post vectors into
// per-frame pending banks. A CPU read of a termination register returns and
// clears its bitmap, and a read of a summary register returns the frame's
// per-register OR with no side effect. One interrupt per frame.
// Assumes read data is registered: rd_data is valid the cycle after rd_en.
module msi_term_unit
    import msi_term_pkg::*;
#(
    parameter int NUM_FRAMES     = 16,
    parameter int REGS_PER_FRAME = 8,
    parameter int VECS_PER_REG   = 16,
    parameter int STRIDE_LOG2    = 16,
    parameter int DATA_W         = 32,
    parameter int ADDR_W         = STRIDE_LOG2
                                   + $clog2(NUM_FRAMES * REGS_PER_FRAME + NUM_FRAMES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    output logic [NUM_FRAMES-1:0] irq
);
    localparam int FRAME_W = $clog2(NUM_FRAMES);
    localparam int IDX_W   = $clog2(REGS_PER_FRAME);
    localparam int VEC_W   = $clog2(VECS_PER_REG);

    hit_e               wr_hit;
    hit_e               rd_hit;
    logic [FRAME_W-1:0] wr_frame;
    logic [FRAME_W-1:0] rd_frame;
    logic [IDX_W-1:0]   wr_idx;
    logic [IDX_W-1:0]   rd_idx;
    logic [VEC_W-1:0]   wr_vec;

    logic [VECS_PER_REG-1:0]   sel_bits [NUM_FRAMES];
    logic [REGS_PER_FRAME-1:0] summ     [NUM_FRAMES];

    // Only the vector field of the write data is used
    assign wr_vec = wr_data[VEC_W-1:0];
    logic unused_wr_hi;
    assign unused_wr_hi = ^wr_data[DATA_W-1:VEC_W];

    msi_addr_decode #(
        .NUM_FRAMES(NUM_FRAMES), .REGS_PER_FRAME(REGS_PER_FRAME),
        .STRIDE_LOG2(STRIDE_LOG2), .ADDR_W(ADDR_W),
        .FRAME_W(FRAME_W), .IDX_W(IDX_W)
    ) u_wr_dec (
        .addr(wr_addr), .hit(wr_hit), .frame(wr_frame), .idx(wr_idx)
    );

    msi_addr_decode #(
        .NUM_FRAMES(NUM_FRAMES), .REGS_PER_FRAME(REGS_PER_FRAME),
        .STRIDE_LOG2(STRIDE_LOG2), .ADDR_W(ADDR_W),
        .FRAME_W(FRAME_W), .IDX_W(IDX_W)
    ) u_rd_dec (
        .addr(rd_addr), .hit(rd_hit), .frame(rd_frame), .idx(rd_idx)
    );

    // One pending bank per frame, each steered by the decoded frame number
    generate
        for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
            logic set_here;
            logic clr_here;
            assign set_here = wr_en && (wr_hit == HIT_TERM) && (wr_frame == FRAME_W'(f));
            assign clr_here = rd_en && (rd_hit == HIT_TERM) && (rd_frame == FRAME_W'(f));

            msi_pend_bank #(
                .REGS_PER_FRAME(REGS_PER_FRAME), .VECS_PER_REG(VECS_PER_REG),
                .IDX_W(IDX_W), .VEC_W(VEC_W)
            ) u_bank (
                .clk(clk), .rst_n(rst_n),
                .set_en(set_here), .set_idx(wr_idx), .set_vec(wr_vec),
                .clr_en(clr_here), .clr_idx(rd_idx),
                .sel_bits(sel_bits[f]), .summary(summ[f]), .irq(irq[f])
            );
        end
    endgenerate

    // Registered read mux: bitmap, summary or zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            case (rd_hit)
                HIT_TERM: rd_data <= DATA_W'(sel_bits[rd_frame]);
                HIT_SUM:  rd_data <= DATA_W'(summ[rd_frame]);
                default:  rd_data <= '0;
            endcase
        end else begin
            rd_data <= '0;
        end
    end

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data >> VECS_PER_REG) == '0);                                // R3
    AST_SUM_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_hit == HIT_SUM && !wr_en) |=> $stable(irq));        // R6
    AST_NONE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_hit == HIT_NONE) |=> (rd_data == '0));              // R8

endmodule

// File: tb/sim_msi_term_unit.sv
`timescale 1ns/1ps
// sim_msi_term_unit: scoreboard bench. Driver tasks update a reference model
// and push predicted read data; a monitor pops and compares after each read.
module sim_msi_term_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [23:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [23:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [15:0] irq;

    int checks = 0;
    int errors = 0;

    logic [15:0] m [16][8];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    msi_term_unit u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    // 200 MHz clock
    always #2.5 clk = ~clk;

    function automatic logic [23:0] term_addr(int f, int x);
        return 24'(f * 32'h80000 + x * 32'h10000);
    endfunction

    function automatic logic [23:0] sum_addr(int f);
        return 24'(32'h800000 + f * 32'h10000);
    endfunction

    function automatic logic [15:0] model_irq();
        logic [15:0] v = '0;
        for (int f = 0; f < 16; f++)
            for (int x = 0; x < 8; x++)
                if (m[f][x] != 16'h0) v[f] = 1'b1;
        return v;
    endfunction

    // Monitor: after each edge that saw rd_en, compare against the queue
    always @(posedge clk) begin
        logic fired;
        fired = rd_en;
        #1;
        if (fired) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: actual %h expected none", rd_data);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", t, rd_data, e);
                end
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    task automatic post(int f, int x, int vec, logic [27:0] junk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = term_addr(f, x); wr_data = {junk, 4'(vec)};
        m[f][x][vec] = 1'b1;
        idle();
    endtask

    task automatic post_raw(logic [23:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        idle();
    endtask

    task automatic read_term(int f, int x, string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = term_addr(f, x);
        exp_q.push_back({16'h0, m[f][x]}); tag_q.push_back(tag);
        m[f][x] = 16'h0;
        idle();
    endtask

    task automatic read_sum(int f, string tag);
        logic [7:0] s = '0;
        for (int x = 0; x < 8; x++) s[x] = (m[f][x] != 16'h0);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = sum_addr(f);
        exp_q.push_back({24'h0, s}); tag_q.push_back(tag);
        idle();
    endtask

    task automatic read_raw(logic [23:0] a, string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        exp_q.push_back(32'h0); tag_q.push_back(tag);
        idle();
    endtask

    // Write (f,x,vec) and read (rf,rx) in the same cycle
    task automatic post_and_read(int f, int x, int vec, int rf, int rx, string tag);
        logic [15:0] e;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = term_addr(f, x); wr_data = 32'(vec);
        rd_en = 1'b1; rd_addr = term_addr(rf, rx);
        e = m[rf][rx];
        exp_q.push_back({16'h0, e}); tag_q.push_back(tag);
        m[f][x][vec] = 1'b1;
        m[rf][rx] = m[rf][rx] & ~e;
        idle();
    endtask

    task automatic check_irq(string tag);
        logic [15:0] e;
        e = model_irq();
        @(negedge clk);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s: irq actual %h expected %h", tag, irq, e);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #(5ns * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int f = 0; f < 16; f++)
            for (int x = 0; x < 8; x++) m[f][x] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();

        // R1: reset state
        check_irq("R1 irq after reset");
        read_term(0, 0, "R1 term read after reset");
        read_sum(15, "R1 summary after reset");

        // R2/R3/R4/R6/R7: single vector, upper data bits are junk
        post(3, 5, 9, 28'hABCDEF0);
        check_irq("R7 irq raised by frame 3");
        read_sum(3, "R6 summary frame 3");
        read_sum(3, "R6 summary reread no side effect");
        check_irq("R6 irq kept after summary read");
        read_term(3, 5, "R2 R3 bitmap of (3,5)");
        read_term(3, 5, "R4 second read empty");
        check_irq("R7 irq dropped after clear");

        // R5: repeated vector, last register of last frame
        post(15, 7, 0, 28'h0);
        post(15, 7, 15, 28'hFFFFFFF);
        post(15, 7, 15, 28'h1234567);
        post(15, 7, 7, 28'h0);
        read_term(15, 7, "R5 repeated vector single bit");

        // R6/R7: two registers in frame 0
        post(0, 0, 3, 28'h0);
        post(0, 7, 12, 28'h0);
        read_sum(0, "R6 summary two registers");
        read_term(0, 0, "R4 clear reg 0 only");
        read_sum(0, "R6 summary after partial clear");
        check_irq("R7 irq stays with reg 7 pending");
        read_term(0, 7, "R4 clear reg 7");
        check_irq("R7 irq low after both cleared");

        // R8: ignored writes and zero unmapped reads
        post_raw(sum_addr(2), 32'h5);
        post_raw(24'h010004, 32'h3);
        post_raw(24'h900000, 32'h1);
        post_raw(24'hFF0000, 32'h2);
        check_irq("R8 ignored writes raise nothing");
        read_sum(2, "R8 summary write ignored");
        post(0, 1, 2, 28'h0);
        read_raw(24'h010004, "R8 misaligned read zero");
        read_raw(24'h900000, "R8 beyond summary read zero");
        read_term(0, 1, "R8 unmapped read cleared nothing");

        // R9: write and read of one register in the same cycle
        post(4, 2, 1, 28'h0);
        post_and_read(4, 2, 6, 4, 2, "R9 read returns old bitmap");
        read_term(4, 2, "R9 new vector survives");
        post(4, 2, 1, 28'h0);
        post_and_read(4, 2, 1, 4, 2, "R9 rewrite of reported vector");
        read_term(4, 2, "R9 reported vector cleared");
        post(4, 2, 5, 28'h0);
        post_and_read(4, 3, 0, 4, 2, "R9 other register in same frame");
        read_term(4, 3, "R9 other register set");
        check_irq("R7 final irq");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule